// File: doc/BRIEF.md
# Clock Generator Power-Good and Power-Down Sequencer

This block controls how a multi-output clock generator starts and stops. A single input pin has two roles. Until it is first seen high, it is a power-good strobe. At that moment the block captures the configuration straps once: the CPU frequency code, the SATA/SRC select, the 12/48 MHz select and the debug-port CPU clock enable. From then on, the same pin is an active-low power-down request. The request is synchronized and must be qualified before the block acts on it.

When power-down is qualified, the differential outputs are parked low at once. Each single-ended output is parked at its next high-to-low transition, so no output is cut short. Only when every output is parked does the block drop the oscillator/PLL enable. When the request is released, the oscillator is enabled again, but all outputs stay held until the PLL lock input is seen. A flag is raised if lock takes longer than a configurable number of reference cycles. The PLLs and pad drivers are outside the block; they are represented by the lock input and by the phase levels of the single-ended clocks.

Top module: `clkgen_pwr_seq`

## Requirements
- R1: After reset, straps_valid_o, lock_timeout_o are 0, osc_en_o is 1, and diff_hold_o and every se_hold_o bit are 1. A low pin before the first high sample is not treated as power-down.
- R2: On the first synchronized high sample of pwr_pin_i, the block latches the straps and raises straps_valid_o. fs_code_o, sata_sel_o, sel_12_48_o and itp_en_o then show the captured strap values.
- R3: Once straps_valid_o is 1 and test_mode_i is 0, later changes on the strap inputs and further pin toggles leave the latched strap outputs unchanged.
- R4: While test_mode_i is 1, the latched straps are reloaded on every cycle in which the synchronized pin is high.
- R5: cpu_freq_o decodes the latched fs_code_o bits [2:1], with bit 0 ignored: 0 means 100 MHz, 1 means 83.33 MHz, 2 means 133.33 MHz and 3 means 166.67 MHz.
- R6: After capture, all outputs stay held while pll_lock_i is 0. Once lock is seen, diff_hold_o and then se_hold_o are released within a few cycles.
- R7: Power-down starts only after the synchronized pin is seen low on two consecutive cycles. A one-cycle low pulse has no effect.
- R8: On power-down, diff_hold_o rises immediately. Each se_hold_o bit is set only on a high-to-low transition of its se_level_i bit, and stays 0 while that level is held high.
- R9: osc_en_o falls only after diff_hold_o and every se_hold_o bit are 1.
- R10: A high pin while the oscillator is off sets osc_en_o to 1 again. The outputs stay held until the PLL lock returns.
- R11: If the request is already low right after capture, the block goes straight to the off state and never releases any output.
- R12: lock_timeout_o rises when pll_lock_i has not come within LOCK_TIMEOUT cycles of waiting. It clears once lock is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock (CPU complement clock domain) |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pwr_pin_i | input | 1 | Dual-role pin: power-good, then active-low power-down request |
| test_mode_i | input | 1 | Allows the straps to be recaptured |
| fs_strap_i | input | 3 | Frequency select strap {C,B,A} |
| sata_sel_strap_i | input | 1 | SATA/SRC select strap |
| sel_12_48_strap_i | input | 1 | 12/48 MHz select strap |
| itp_en_strap_i | input | 1 | Debug-port CPU clock enable strap |
| se_level_i | input | N_SE | Current level of each single-ended clock |
| pll_lock_i | input | 1 | PLL lock indication |
| straps_valid_o | output | 1 | Straps have been captured |
| fs_code_o | output | 3 | Latched frequency select code |
| cpu_freq_o | output | 2 | Decoded CPU frequency |
| sata_sel_o | output | 1 | Latched SATA/SRC select |
| sel_12_48_o | output | 1 | Latched 12/48 select |
| itp_en_o | output | 1 | Latched debug-port enable |
| se_hold_o | output | N_SE | Hold-low command per single-ended output |
| diff_hold_o | output | 1 | Hold-low command for the differential outputs |
| osc_en_o | output | 1 | Oscillator/PLL enable |
| lock_timeout_o | output | 1 | Lock did not arrive in time |

## Verification
The bench goes after the pin's dual role. A low pin before power-good must not start power-down. A one-cycle low pulse must not either; a design that skips the two-sample qualification would park the outputs on that glitch. One single-ended clock is frozen high during power-down: an early park would shorten a pulse, and an oscillator that stops before that output parks would cut it mid-pulse. Strap changes are made after capture, with test mode both off and on, which exposes a latch that is not one-shot. A request that is already low at capture must lead to the off state without a single output being released.

// File: rtl/pdseq_pkg.sv
package pdseq_pkg;
  typedef enum logic [2:0] {
    ST_WAIT_PG, ST_WAIT_LOCK, ST_RUN, ST_PARK, ST_OFF
  } seq_state_e;

  typedef enum logic [1:0] {
    FREQ_100 = 2'd0, FREQ_83 = 2'd1, FREQ_133 = 2'd2, FREQ_166 = 2'd3
  } cpu_freq_e;

  function automatic cpu_freq_e fs_to_freq(logic [2:0] fs);
    case (fs[2:1])
      2'b00:   return FREQ_100;
      2'b01:   return FREQ_83;
      2'b10:   return FREQ_133;
      default: return FREQ_166;
    endcase
  endfunction
endpackage

// File: rtl/pdseq_sync2.sv
module pdseq_sync2 #(
  parameter int unsigned W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end
  assign q_o = s2_q;
endmodule

// File: rtl/pdseq_strap_latch.sv
module pdseq_strap_latch
  import pdseq_pkg::*;
#(
  parameter int unsigned FS_W = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            pin_s_i,
  input  logic            test_mode_i,
  input  logic [FS_W-1:0] fs_i,
  input  logic            sata_sel_i,
  input  logic            sel_12_48_i,
  input  logic            itp_en_i,
  output logic            valid_o,
  output logic [FS_W-1:0] fs_o,
  output logic            sata_sel_o,
  output logic            sel_12_48_o,
  output logic            itp_en_o,
  output logic [1:0]      cpu_freq_o
);
  logic            valid_q;
  logic [FS_W-1:0] fs_q;
  logic            sata_q, s1248_q, itp_q;
  logic            load;

  // one-shot unless test mode reopens it
  assign load = pin_s_i && (!valid_q || test_mode_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      fs_q    <= '0;
      sata_q  <= 1'b0;
      s1248_q <= 1'b0;
      itp_q   <= 1'b0;
    end else if (load) begin
      valid_q <= 1'b1;
      fs_q    <= fs_i;
      sata_q  <= sata_sel_i;
      s1248_q <= sel_12_48_i;
      itp_q   <= itp_en_i;
    end
  end

  assign valid_o     = valid_q;
  assign fs_o        = fs_q;
  assign sata_sel_o  = sata_q;
  assign sel_12_48_o = s1248_q;
  assign itp_en_o    = itp_q;
  assign cpu_freq_o  = fs_to_freq(fs_q[2:0]);

  // R2
  capture_on_pg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_q) |-> $past(pin_s_i));
  // R3
  straps_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_q && !test_mode_i) |=> ($stable(fs_q) && $stable(sata_q) &&
                                   $stable(s1248_q) && $stable(itp_q)));
endmodule

// File: rtl/pdseq_se_park.sv
module pdseq_se_park (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic force_i,
  input  logic run_i,
  input  logic lvl_i,
  output logic hold_o
);
  logic lvl_q, hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q  <= 1'b0;
      hold_q <= 1'b1;
    end else begin
      lvl_q <= lvl_i;
      if (force_i)             hold_q <= 1'b1;
      else if (run_i)          hold_q <= 1'b0;
      else if (lvl_q && !lvl_i) hold_q <= 1'b1;  // park at falling edge
    end
  end

  assign hold_o = hold_q;

  // R8
  park_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!force_i && !run_i && hold_q) |=> hold_q);
  // R8
  no_park_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!force_i && !run_i && !hold_q && lvl_i) |=> !hold_q);
endmodule

// File: rtl/pdseq_ctrl.sv
module pdseq_ctrl
  import pdseq_pkg::*;
#(
  parameter int unsigned LOCK_TIMEOUT = 25800
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pin_s_i,
  input  logic       straps_valid_i,
  input  logic       pll_lock_i,
  input  logic       all_parked_i,
  output seq_state_e state_o,
  output logic       osc_en_o,
  output logic       diff_hold_o,
  output logic       lock_timeout_o
);
  localparam int unsigned CW = $clog2(LOCK_TIMEOUT + 1);

  seq_state_e    state_q, state_d;
  logic          low1_q, pd_q, timeout_q;
  logic [CW-1:0] cnt_q;

  // two consecutive low samples after capture
  assign pd_q = straps_valid_i && !pin_s_i && low1_q;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_WAIT_PG:   if (straps_valid_i) state_d = ST_WAIT_LOCK;
      ST_WAIT_LOCK: if (pd_q) state_d = ST_PARK;
                    else if (pll_lock_i) state_d = ST_RUN;
      ST_RUN:       if (pd_q) state_d = ST_PARK;
      ST_PARK:      if (pin_s_i) state_d = ST_WAIT_LOCK;
                    else if (all_parked_i) state_d = ST_OFF;
      ST_OFF:       if (pin_s_i) state_d = ST_WAIT_LOCK;
      default:      state_d = ST_WAIT_PG;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_WAIT_PG;
      low1_q    <= 1'b0;
      cnt_q     <= '0;
      timeout_q <= 1'b0;
    end else begin
      state_q <= state_d;
      low1_q  <= !pin_s_i;
      if (state_q == ST_WAIT_LOCK) begin
        if (cnt_q != CW'(LOCK_TIMEOUT)) cnt_q <= cnt_q + CW'(1);
        timeout_q <= (cnt_q == CW'(LOCK_TIMEOUT)) && !pll_lock_i;
      end else begin
        cnt_q     <= '0;
        timeout_q <= 1'b0;
      end
    end
  end

  assign state_o        = state_q;
  assign osc_en_o       = (state_q != ST_OFF);
  assign diff_hold_o    = (state_q != ST_RUN);
  assign lock_timeout_o = timeout_q;

  // R7
  pd_two_sample_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_PARK && $past(state_q) == ST_RUN) |-> (!$past(pin_s_i) && !$past(pin_s_i, 2)));
  // R6
  release_on_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(diff_hold_o) |-> $past(pll_lock_i));
  // R12
  timeout_waiting_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(timeout_q) |-> ($past(state_q) == ST_WAIT_LOCK && !$past(pll_lock_i)));
endmodule

// File: rtl/clkgen_pwr_seq.sv
module clkgen_pwr_seq
  import pdseq_pkg::*;
#(
  parameter int unsigned N_SE         = 3,
  parameter int unsigned LOCK_TIMEOUT = 25800
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            pwr_pin_i,
  input  logic            test_mode_i,
  input  logic [2:0]      fs_strap_i,
  input  logic            sata_sel_strap_i,
  input  logic            sel_12_48_strap_i,
  input  logic            itp_en_strap_i,
  input  logic [N_SE-1:0] se_level_i,
  input  logic            pll_lock_i,
  output logic            straps_valid_o,
  output logic [2:0]      fs_code_o,
  output logic [1:0]      cpu_freq_o,
  output logic            sata_sel_o,
  output logic            sel_12_48_o,
  output logic            itp_en_o,
  output logic [N_SE-1:0] se_hold_o,
  output logic            diff_hold_o,
  output logic            osc_en_o,
  output logic            lock_timeout_o
);
  logic       pin_s;
  seq_state_e state;
  logic       se_force, se_run;

  pdseq_sync2 #(.W(1)) u_sync (
    .clk_i, .rst_ni, .d_i(pwr_pin_i), .q_o(pin_s)
  );

  pdseq_strap_latch #(.FS_W(3)) u_straps (
    .clk_i, .rst_ni,
    .pin_s_i(pin_s), .test_mode_i,
    .fs_i(fs_strap_i), .sata_sel_i(sata_sel_strap_i),
    .sel_12_48_i(sel_12_48_strap_i), .itp_en_i(itp_en_strap_i),
    .valid_o(straps_valid_o), .fs_o(fs_code_o), .sata_sel_o,
    .sel_12_48_o, .itp_en_o, .cpu_freq_o
  );

  pdseq_ctrl #(.LOCK_TIMEOUT(LOCK_TIMEOUT)) u_ctrl (
    .clk_i, .rst_ni, .pin_s_i(pin_s), .straps_valid_i(straps_valid_o),
    .pll_lock_i, .all_parked_i(&se_hold_o), .state_o(state),
    .osc_en_o, .diff_hold_o, .lock_timeout_o
  );

  assign se_run   = (state == ST_RUN);
  assign se_force = (state != ST_RUN) && (state != ST_PARK);

  for (genvar k = 0; k < N_SE; k++) begin : g_se
    pdseq_se_park u_park (
      .clk_i, .rst_ni, .force_i(se_force), .run_i(se_run),
      .lvl_i(se_level_i[k]), .hold_o(se_hold_o[k])
    );
  end

  // R9
  osc_off_parked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !osc_en_o |-> (diff_hold_o && (&se_hold_o)));
endmodule

// File: tb/clkgen_pwr_seq_tb_top.sv
module clkgen_pwr_seq_tb_top;
  localparam int unsigned N_SE = 3;
  localparam int unsigned LT   = 40;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_ni = 1'b0, pin = 1'b0, test_mode = 1'b0;
  logic [2:0] fs = '0;
  logic sata = 1'b0, s1248 = 1'b0, itp = 1'b0;
  logic [N_SE-1:0] se_lvl = '0, freeze = '0;
  logic lock_en = 1'b0, lock;
  int   osc_cnt = 0;

  logic straps_valid, sata_o, s1248_o, itp_o, diff_hold, osc_en, tmo;
  logic [2:0] fs_o;
  logic [1:0] freq_o;
  logic [N_SE-1:0] se_hold;

  clkgen_pwr_seq #(.N_SE(N_SE), .LOCK_TIMEOUT(LT)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .pwr_pin_i(pin), .test_mode_i(test_mode),
    .fs_strap_i(fs), .sata_sel_strap_i(sata), .sel_12_48_strap_i(s1248),
    .itp_en_strap_i(itp), .se_level_i(se_lvl), .pll_lock_i(lock),
    .straps_valid_o(straps_valid), .fs_code_o(fs_o), .cpu_freq_o(freq_o),
    .sata_sel_o(sata_o), .sel_12_48_o(s1248_o), .itp_en_o(itp_o),
    .se_hold_o(se_hold), .diff_hold_o(diff_hold), .osc_en_o(osc_en),
    .lock_timeout_o(tmo)
  );

  // PLL model: lock 8 cycles after the oscillator is stably enabled
  always @(posedge clk) osc_cnt <= osc_en ? osc_cnt + 1 : 0;
  assign lock = lock_en && (osc_cnt >= 8);

  // single-ended clock levels, output k toggles every k+1 cycles
  int tog [N_SE];
  initial for (int k = 0; k < N_SE; k++) tog[k] = 0;
  always @(negedge clk) begin
    for (int k = 0; k < N_SE; k++) begin
      if (freeze[k]) se_lvl[k] <= 1'b1;
      else if (tog[k] >= k) begin
        se_lvl[k] <= ~se_lvl[k];
        tog[k] <= 0;
      end else tog[k] <= tog[k] + 1;
    end
  end

  int n_chk = 0, n_fail = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [1:0] ref_freq(input logic [2:0] f);
    case ({f[2], f[1]})  // R5 table
      2'b00: return 2'd0;
      2'b01: return 2'd1;
      2'b10: return 2'd2;
      default: return 2'd3;
    endcase
  endfunction

  typedef struct {
    logic [2:0] fs; logic sata; logic s1248; logic itp; string req;
  } exp_t;
  exp_t sb_q[$];

  // monitor: pops each expectation and compares latched strap outputs
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      chk(straps_valid === 1'b1, e.req, int'(straps_valid), 1);
      chk(fs_o === e.fs && sata_o === e.sata && s1248_o === e.s1248 && itp_o === e.itp,
          e.req, int'({fs_o, sata_o, s1248_o, itp_o}), int'({e.fs, e.sata, e.s1248, e.itp}));
      chk(freq_o === ref_freq(e.fs), {e.req, " R5"}, int'(freq_o), int'(ref_freq(e.fs)));
    end
  end

  task automatic sb_push(input logic [2:0] f, input logic s, input logic t,
                         input logic i, input string req);
    exp_t e;
    e.fs = f; e.sata = s; e.s1248 = t; e.itp = i; e.req = req;
    @(posedge clk); #1;
    sb_q.push_back(e);
    @(negedge clk); @(negedge clk);
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 20000, 0);
    summary();
  end

  logic saw_release;

  initial begin
    cyc(3);
    rst_ni = 1'b1;
    cyc(1);
    // R1 reset state
    chk(straps_valid === 1'b0, "R1", int'(straps_valid), 0);
    chk(diff_hold === 1'b1 && se_hold === '1, "R1", int'({diff_hold, se_hold}), 15);
    chk(osc_en === 1'b1 && tmo === 1'b0, "R1", int'({osc_en, tmo}), 2);
    cyc(5);
    chk(straps_valid === 1'b0 && osc_en === 1'b1, "R1", int'({straps_valid, osc_en}), 1);

    // R2 capture
    fs = 3'b101; sata = 1'b1; s1248 = 1'b0; itp = 1'b1;
    pin = 1'b1;
    for (int i = 0; i < 6 && straps_valid !== 1'b1; i++) cyc(1);
    chk(straps_valid === 1'b1, "R2", int'(straps_valid), 1);
    sb_push(3'b101, 1'b1, 1'b0, 1'b1, "R2");

    // R6 held while no lock
    cyc(5);
    chk(diff_hold === 1'b1 && se_hold === '1, "R6", int'({diff_hold, se_hold}), 15);

    // R12 timeout
    cyc(20);
    chk(tmo === 1'b0, "R12", int'(tmo), 0);
    for (int i = 0; i < 30 && tmo !== 1'b1; i++) cyc(1);
    chk(tmo === 1'b1, "R12", int'(tmo), 1);
    lock_en = 1'b1;
    for (int i = 0; i < 6 && diff_hold !== 1'b0; i++) cyc(1);
    chk(diff_hold === 1'b0, "R6", int'(diff_hold), 0);
    cyc(2);
    chk(se_hold === '0, "R6", int'(se_hold), 0);
    chk(tmo === 1'b0, "R12", int'(tmo), 0);

    // R3 and R7: strap change plus one-cycle low glitch
    fs = 3'b010; sata = 1'b0; s1248 = 1'b1; itp = 1'b0;
    pin = 1'b0;
    cyc(1);
    pin = 1'b1;
    cyc(6);
    chk(diff_hold === 1'b0 && se_hold === '0, "R7", int'({diff_hold, se_hold}), 0);
    sb_push(3'b101, 1'b1, 1'b0, 1'b1, "R3");

    // R4 test-mode recapture, R5 all codes
    test_mode = 1'b1;
    for (int v = 0; v < 8; v++) begin
      fs = 3'(v); sata = v[0]; s1248 = v[1]; itp = v[2];
      cyc(4);
      sb_push(3'(v), v[0], v[1], v[2], "R4");
    end
    test_mode = 1'b0;
    cyc(1);
    fs = 3'b011; sata = 1'b0; s1248 = 1'b0; itp = 1'b0;
    cyc(4);
    sb_push(3'b111, 1'b1, 1'b1, 1'b1, "R3");

    // R7/R8/R9 power-down with output 1 frozen high
    freeze = 3'b010;
    cyc(2);
    pin = 1'b0;
    for (int i = 0; i < 8 && diff_hold !== 1'b1; i++) cyc(1);
    chk(diff_hold === 1'b1, "R7", int'(diff_hold), 1);
    cyc(10);
    chk(se_hold[1] === 1'b0, "R8", int'(se_hold[1]), 0);
    chk(se_hold[0] === 1'b1 && se_hold[2] === 1'b1, "R8", int'(se_hold), 5);
    chk(osc_en === 1'b1, "R9", int'(osc_en), 1);
    freeze = '0;
    for (int i = 0; i < 12 && osc_en !== 1'b0; i++) cyc(1);
    chk(osc_en === 1'b0, "R9", int'(osc_en), 0);
    chk(se_hold === '1 && diff_hold === 1'b1, "R9", int'({diff_hold, se_hold}), 15);

    // R10 power back up
    cyc(5);
    chk(osc_en === 1'b0, "R10", int'(osc_en), 0);
    pin = 1'b1;
    for (int i = 0; i < 5 && osc_en !== 1'b1; i++) cyc(1);
    chk(osc_en === 1'b1, "R10", int'(osc_en), 1);
    chk(diff_hold === 1'b1 && se_hold === '1, "R10", int'({diff_hold, se_hold}), 15);
    for (int i = 0; i < 14 && diff_hold !== 1'b0; i++) cyc(1);
    chk(diff_hold === 1'b0, "R10", int'(diff_hold), 0);

    // R11 power-down as initial state
    rst_ni = 1'b0; lock_en = 1'b0; pin = 1'b0;
    cyc(2);
    rst_ni = 1'b1;
    cyc(2);
    fs = 3'b111; sata = 1'b1; s1248 = 1'b1; itp = 1'b1;
    pin = 1'b1;
    cyc(1);
    pin = 1'b0;
    saw_release = 1'b0;
    for (int i = 0; i < 20; i++) begin
      cyc(1);
      if (diff_hold !== 1'b1 || se_hold !== '1) saw_release = 1'b1;
    end
    chk(!saw_release, "R11", int'(saw_release), 0);
    chk(osc_en === 1'b0, "R11", int'(osc_en), 0);
    sb_push(3'b111, 1'b1, 1'b1, 1'b1, "R11");

    cyc(2);
    summary();
  end
endmodule